// File: doc/BRIEF.md
# Two's Complement Adder-Subtractor with Status Flags

This block is a purely combinational 32-bit adder-subtractor for signed two's complement operands. A single control input chooses between addition and subtraction. Both operations run on one ripple-carry chain of full-adder cells. For a subtraction, the second operand is bit-inverted and the chain's carry-in is forced high, so no separate subtractor is needed.

Alongside the 32-bit result, the block produces three status flags: zero, signed overflow and negative. A downstream comparison stage decides relations such as less-than or equal from these flags alone. The zero flag comes from an OR tree whose gates have at most four inputs each, followed by an inversion. The overflow flag comes only from the sign bits that enter and leave the most significant adder cell.

The block has no clock, no reset and no state. Its outputs follow its inputs after the ripple delay.

Top module: `addsub_flag_unit`

## Requirements
- R1: With `do_sub` = 0, `result` equals `op_a + op_b` modulo 2^32.
- R2: With `do_sub` = 1, `result` equals `op_a - op_b` modulo 2^32. The design forms this by inverting every bit of `op_b` and forcing the carry-in to 1.
- R3: `flag_z` is 1 exactly when all 32 bits of `result` are 0. It is formed by a reduction tree of gates with at most 4 inputs each.
- R4: `flag_n` equals bit 31 of `result`.
- R5: With `do_sub` = 0, `flag_v` is 1 exactly when the signed sum of the operands lies outside the range -2^31 to 2^31-1.
- R6: With `do_sub` = 1, `flag_v` is 1 exactly when the signed difference of the operands lies outside the range -2^31 to 2^31-1.
- R7: `flag_v` is 0 whenever bit 31 of `op_a` differs from bit 31 of the effective second operand. The effective second operand is `op_b`, inverted when `do_sub` = 1.
- R8: Adding 1 to 0x7FFFFFFF gives 0x80000000 with `flag_v` = 1, `flag_n` = 1 and `flag_z` = 0.
- R9: Subtracting 1 from 0x80000000 gives 0x7FFFFFFF with `flag_v` = 1, `flag_n` = 0 and `flag_z` = 0.
- R10: Subtracting 0 from 0 gives 0 with `flag_z` = 1, `flag_v` = 0 and `flag_n` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand, signed two's complement |
| op_b | input | 32 | Second operand, signed two's complement |
| do_sub | input | 1 | 0 selects addition, 1 selects subtraction |
| result | output | 32 | Sum or difference, modulo 2^32 |
| flag_z | output | 1 | High when the result is all zeros |
| flag_v | output | 1 | High on signed overflow |
| flag_n | output | 1 | Copy of the result's sign bit |

## Verification
The embedded checks assume that all inputs are driven to known 0/1 values and are settled when the checks evaluate them. The bench meets this by changing inputs only on the falling clock edge. It samples the outputs a fixed time later, well before the next change. The random vectors are mixed with operands pinned at the signed extremes, zero and all-ones. This drives the overflow logic through both same-sign cases, both mixed-sign cases, and the carry ripple that runs the full length of the chain.

// File: rtl/addsub_pkg.sv
`timescale 1ns/1ps
package addsub_pkg;

  // Number of nodes on level l of a reduction tree: w leaves, f-input gates.
  function automatic int tree_width(int w, int f, int l);
    int r;
    r = w;
    for (int i = 0; i < l; i++) r = (r + f - 1) / f;
    return r;
  endfunction

  // Number of gate levels needed to reduce w leaves to one node.
  function automatic int tree_levels(int w, int f);
    int r;
    int n;
    r = w;
    n = 0;
    for (int i = 0; i < 64; i++) begin
      if (r > 1) begin
        r = (r + f - 1) / f;
        n = n + 1;
      end
    end
    return n;
  endfunction

  // Index of the first node of level l in a flattened node vector.
  function automatic int tree_offset(int w, int f, int l);
    int o;
    o = 0;
    for (int i = 0; i < l; i++) o = o + tree_width(w, f, i);
    return o;
  endfunction

endpackage

// File: rtl/addsub_fa.sv
`timescale 1ns/1ps
module addsub_fa (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = x ^ y ^ ci;
  assign co = (x & y) | (ci & (x ^ y));
endmodule

// File: rtl/addsub_ripple.sv
`timescale 1ns/1ps
module addsub_ripple #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] xa,
  input  logic [WIDTH-1:0] xb,
  input  logic             cin,
  output logic [WIDTH-1:0] sum
);
  logic [WIDTH-1:0] carry;

  assign carry[0] = cin;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (i < WIDTH - 1) begin : g_cell
        addsub_fa u_fa (
          .x  (xa[i]),
          .y  (xb[i]),
          .ci (carry[i]),
          .s  (sum[i]),
          .co (carry[i+1])
        );
      end else begin : g_top
        // The carry out of the top bit is never consumed: sum only.
        assign sum[i] = xa[i] ^ xb[i] ^ carry[i];
      end
    end
  endgenerate
endmodule

// File: rtl/addsub_zero_tree.sv
`timescale 1ns/1ps
module addsub_zero_tree #(
  parameter int WIDTH = 32,
  parameter int FANIN = 4
) (
  input  logic [WIDTH-1:0] bits,
  output logic             all_zero
);
  import addsub_pkg::*;

  localparam int LEVELS = tree_levels(WIDTH, FANIN);
  localparam int TOTAL  = tree_offset(WIDTH, FANIN, LEVELS) + 1;

  logic [TOTAL-1:0] node;

  assign node[WIDTH-1:0] = bits;

  generate
    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
      localparam int IW = tree_width(WIDTH, FANIN, l);
      localparam int OW = tree_width(WIDTH, FANIN, l + 1);
      localparam int IO = tree_offset(WIDTH, FANIN, l);
      localparam int OO = tree_offset(WIDTH, FANIN, l + 1);
      for (genvar g = 0; g < OW; g++) begin : g_grp
        localparam int N = (IW - g * FANIN < FANIN) ? (IW - g * FANIN) : FANIN;
        assign node[OO+g] = |node[IO+g*FANIN +: N];
      end
    end
  endgenerate

  assign all_zero = ~node[TOTAL-1];

  always_comb begin
    a_r3_zero_tree: assert (all_zero == (bits == '0))
      else $error("zero tree disagrees with its leaves");
  end
endmodule

// File: rtl/addsub_flags.sv
`timescale 1ns/1ps
module addsub_flags #(
  parameter int WIDTH = 32,
  parameter int FANIN = 4
) (
  input  logic             xa_msb,
  input  logic             xb_msb,
  input  logic [WIDTH-1:0] sum,
  output logic             z,
  output logic             v,
  output logic             n
);
  logic s_msb;

  assign s_msb = sum[WIDTH-1];

  addsub_zero_tree #(
    .WIDTH (WIDTH),
    .FANIN (FANIN)
  ) u_zero (
    .bits     (sum),
    .all_zero (z)
  );

  // Overflow: both effective operands share a sign that the result lacks.
  assign v = (xa_msb & xb_msb & ~s_msb) | (~xa_msb & ~xb_msb & s_msb);
  assign n = s_msb;

  always_comb begin
    // R5 / R6: an overflowed result always carries the wrong sign
    a_r6_ovf_sign_flip: assert (!v || (n != xa_msb))
      else $error("overflow flagged without sign flip");
  end
endmodule

// File: rtl/addsub_flag_unit.sv
`timescale 1ns/1ps
module addsub_flag_unit #(
  parameter int WIDTH = 32,
  parameter int FANIN = 4
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             do_sub,
  output logic [WIDTH-1:0] result,
  output logic             flag_z,
  output logic             flag_v,
  output logic             flag_n
);
  logic [WIDTH-1:0] eff_b;

  // Subtraction: invert B here, the +1 enters as the chain's carry-in.
  assign eff_b = op_b ^ {WIDTH{do_sub}};

  addsub_ripple #(
    .WIDTH (WIDTH)
  ) u_chain (
    .xa  (op_a),
    .xb  (eff_b),
    .cin (do_sub),
    .sum (result)
  );

  addsub_flags #(
    .WIDTH (WIDTH),
    .FANIN (FANIN)
  ) u_flags (
    .xa_msb (op_a[WIDTH-1]),
    .xb_msb (eff_b[WIDTH-1]),
    .sum    (result),
    .z      (flag_z),
    .v      (flag_v),
    .n      (flag_n)
  );

  always_comb begin
    if (!do_sub) begin
      a_r1_add_result: assert (result == op_a + op_b)
        else $error("add result mismatch");
    end else begin
      a_r2_sub_result: assert (result == op_a - op_b)
        else $error("subtract result mismatch");
    end
    if (op_a[WIDTH-1] != eff_b[WIDTH-1]) begin
      a_r7_no_overflow: assert (!flag_v)
        else $error("overflow on mixed-sign operands");
    end
    a_r4_neg_is_msb: assert (flag_n == result[WIDTH-1])
      else $error("negative flag differs from result sign");
  end
endmodule

// File: tb/tb_addsub_flag_unit.sv
`timescale 1ns/1ps
module tb_addsub_flag_unit;
  logic        clk;
  logic [31:0] op_a;
  logic [31:0] op_b;
  logic        do_sub;
  logic [31:0] result;
  logic        flag_z;
  logic        flag_v;
  logic        flag_n;

  int n_checks;
  int n_fail;
  int cycles;

  addsub_flag_unit dut (
    .op_a   (op_a),
    .op_b   (op_b),
    .do_sub (do_sub),
    .result (result),
    .flag_z (flag_z),
    .flag_v (flag_v),
    .flag_n (flag_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles >= 200000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 200000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks = n_checks + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s a=%h b=%h sub=%0b: actual %h expected %h", tag, op_a, op_b, do_sub, act, exp);
    end
  endtask

  // Behavioural reference: 33-bit signed arithmetic, overflow when the
  // two top bits of the wide result disagree.
  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic s);
    logic [32:0] wa;
    logic [32:0] wb;
    logic [32:0] wide;
    logic [31:0] e_sum;
    logic        e_v;
    logic        eff_sign;
    @(negedge clk);
    op_a   = a;
    op_b   = b;
    do_sub = s;
    wa = {a[31], a};
    wb = {b[31], b};
    wide  = s ? (wa - wb) : (wa + wb);
    e_sum = wide[31:0];
    e_v   = wide[32] ^ wide[31];
    #1;
    if (!s) begin
      chk("R1 sum", result, e_sum);
      chk("R5 overflow", {31'b0, flag_v}, {31'b0, e_v});
    end else begin
      chk("R2 difference", result, e_sum);
      chk("R6 overflow", {31'b0, flag_v}, {31'b0, e_v});
    end
    chk("R3 zero", {31'b0, flag_z}, {31'b0, (e_sum == 32'h0)});
    chk("R4 negative", {31'b0, flag_n}, {31'b0, e_sum[31]});
    eff_sign = b[31] ^ s;
    if (a[31] != eff_sign) chk("R7 mixed-sign no overflow", {31'b0, flag_v}, 32'h0);
  endtask

  localparam logic [31:0] EDGE [8] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                                       32'h8000_0000, 32'h8000_0001, 32'h7FFF_FFFE, 32'h5555_5555};

  initial begin
    n_checks = 0;
    n_fail   = 0;
    cycles   = 0;
    op_a = '0;
    op_b = '0;
    do_sub = 1'b0;

    // Idle state: all inputs zero gives a zero sum.
    @(negedge clk);
    #1;
    chk("R3 idle zero", {31'b0, flag_z}, 32'h1);
    chk("R1 idle sum", result, 32'h0);

    // R8: positive overflow
    apply(32'h7FFF_FFFF, 32'h1, 1'b0);
    chk("R8 result", result, 32'h8000_0000);
    chk("R8 v", {31'b0, flag_v}, 32'h1);
    chk("R8 n", {31'b0, flag_n}, 32'h1);
    chk("R8 z", {31'b0, flag_z}, 32'h0);

    // R9: negative overflow by subtraction
    apply(32'h8000_0000, 32'h1, 1'b1);
    chk("R9 result", result, 32'h7FFF_FFFF);
    chk("R9 v", {31'b0, flag_v}, 32'h1);
    chk("R9 n", {31'b0, flag_n}, 32'h0);
    chk("R9 z", {31'b0, flag_z}, 32'h0);

    // R10: zero minus zero
    apply(32'h0, 32'h0, 1'b1);
    chk("R10 result", result, 32'h0);
    chk("R10 z", {31'b0, flag_z}, 32'h1);
    chk("R10 v", {31'b0, flag_v}, 32'h0);
    chk("R10 n", {31'b0, flag_n}, 32'h0);

    // Full carry ripple: all ones plus one, and one minus one.
    apply(32'hFFFF_FFFF, 32'h1, 1'b0);
    apply(32'h1, 32'h1, 1'b1);
    apply(32'h8000_0000, 32'h8000_0000, 1'b0);

    // Every pair of edge operands in both modes.
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int s = 0; s < 2; s++)
          apply(EDGE[i], EDGE[j], s[0]);

    // Random operands, plus operands sharing the sign bit.
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] ra;
      logic [31:0] rb;
      ra = $urandom;
      rb = $urandom;
      if (k % 3 == 1) rb[31] = ra[31];
      if (k % 7 == 2) rb = ra;
      apply(ra, rb, k[0]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule